// File: doc/BRIEF.md
# Masked Priority Interrupt Aggregator

The block gathers sixteen level-sensitive interrupt request lines into one interrupt output for a processor. Each request line passes through a short synchronizer and then drives its own bit of a source register, which follows the line's level with no latching. A writable enable mask, reachable over a 16-bit register bus, decides which of those sources may raise the shared interrupt output.

Software services the interrupt by reading the source location. That read does not return the raw source bits. It returns a vector-table offset computed from the lowest-numbered source that is both pending and enabled. A value of zero means nothing needs service. Reads are purely combinational and change no state, so polling is safe.

Top module: `irq_agg`

## Requirements
- R1: Bit i of the source register takes the level of input `irq_in[i]` after SYNC_STAGES rising clock edges (two by default). It follows the input in both directions and holds nothing once the input falls.
- R2: `irq_out` is high exactly when (source AND mask) has at least one bit set.
- R3: A read of byte offset 0x000 returns (i+1)<<2. Here i is the lowest-numbered bit set in (source AND mask). The read returns 0 when no such bit is set, so bits [1:0] of the value are always 0.
- R4: When several enabled sources are pending at once, the read of offset 0x000 reports the lowest-numbered one, regardless of which higher-numbered ones are also pending.
- R5: Byte offset 0x002 holds the enable mask, with bit i enabling source i. A write there takes effect at the clock edge of the write. `irq_out` and the offset 0x000 value reflect the new mask from that edge, and a read of 0x002 returns the mask.
- R6: Reset sets the mask to 0x0010 and the source register to 0, so `irq_out` is low after reset.
- R7: A write to offset 0x000 leaves the source register and the mask unchanged.
- R8: Reads of any offset other than 0x000 and 0x002 return 0, and writes to them change neither the mask nor the source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Level interrupt request lines, one per source |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Aggregated interrupt, high while any enabled source is pending |

## Verification
The bench builds the block with its defaults: sixteen sources, 16-bit data, 12-bit offsets and a two-stage synchronizer. Every vector value from 4 up to 64 can therefore appear, including the top source reporting 64. The exact two-edge input latency is checked, both before and after it elapses. Random masks and request patterns put several pending enabled sources together, which exercises the lowest-index-wins rule. Unused offsets are chosen at random across the 12-bit space.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int NSRC        = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 'h000,
  parameter logic [ADDR_W-1:0] MASK_OFF = 'h002,
  parameter logic [NSRC-1:0]   MASK_RST = 'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  logic [NSRC-1:0]   sync_q [SYNC_STAGES];
  logic [NSRC-1:0]   src;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   pend;
  logic [DATA_W-1:0] vec;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= irq_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign src = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RST;
    else if (bus_wr && bus_addr == MASK_OFF) mask_q <= bus_wdata[NSRC-1:0];
  end

  assign pend    = src & mask_q;
  assign irq_out = |pend;

  always_comb begin
    vec = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (pend[i]) vec = DATA_W'((i + 1) << 2);
  end

  assign bus_rdata = (bus_addr == SRC_OFF)  ? vec :
                     (bus_addr == MASK_OFF) ? DATA_W'(mask_q) : '0;

  // R2 R3
  vec_irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (vec != '0));

  // R3
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec[1:0] == 2'b00);

  // R5
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MASK_OFF) |=> mask_q == $past(bus_wdata[NSRC-1:0]));

  // R7 R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != MASK_OFF) |=> $stable(mask_q));

  // R6
  reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mask_q == MASK_RST && src == '0));

endmodule

// File: tb/sim_irq_agg.sv
module sim_irq_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mask_m;

  always #4 clk = ~clk;

  irq_agg u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
              .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
              .irq_out(irq_out));

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    exp_vec = 16'h0;
    for (int i = 15; i >= 0; i--) if (p[i]) exp_vec = 16'((i + 1) << 2);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [15:0] lv);
    logic [15:0] d;
    chk({req, " irq_out"}, {15'h0, irq_out}, {15'h0, |(lv & mask_m)});
    rd(12'h000, d); chk({req, " vector"}, d, exp_vec(lv & mask_m));
    rd(12'h002, d); chk({req, " mask"}, d, mask_m);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, lv;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    mask_m = 16'h0010;
    @(negedge clk);
    // R6 reset state
    check_all("R6", 16'h0);

    // R1 latency and bit mapping: source 4 enabled by reset mask
    irq_in = 16'h0010;
    @(negedge clk);
    chk("R1 before 2 edges", {15'h0, irq_out}, 16'h0);
    @(negedge clk);
    chk("R1 after 2 edges", {15'h0, irq_out}, 16'h1);
    rd(12'h000, d); chk("R3 source4", d, 16'd20);

    // R1 no latching
    irq_in = 16'h0;
    settle();
    check_all("R1 release", 16'h0);

    // R5 mask write and immediate effect
    irq_in = 16'h8000;
    settle();
    chk("R2 masked off", {15'h0, irq_out}, 16'h0);
    wr(12'h002, 16'h8000); mask_m = 16'h8000;
    check_all("R5 top source", 16'h8000);
    rd(12'h000, d); chk("R3 vector 64", d, 16'd64);

    // R4 lowest wins
    irq_in = 16'hFFFF;
    wr(12'h002, 16'hFFFF); mask_m = 16'hFFFF;
    settle();
    rd(12'h000, d); chk("R4 all pending", d, 16'd4);
    wr(12'h002, 16'hFF00); mask_m = 16'hFF00;
    rd(12'h000, d); chk("R4 upper half", d, 16'd36);

    // R7 write to source offset ignored
    wr(12'h000, 16'h0000);
    check_all("R7", 16'hFFFF);

    // R8 other offsets
    wr(12'h004, 16'h0000);
    check_all("R8 write", 16'hFFFF);
    rd(12'h006, d); chk("R8 read", d, 16'h0);

    // R2 mask zero
    wr(12'h002, 16'h0000); mask_m = 16'h0;
    check_all("R2 mask zero", 16'hFFFF);

    // random
    for (int n = 0; n < 300; n++) begin
      logic [11:0] oa;
      lv = 16'($urandom) & 16'($urandom);
      irq_in = lv;
      if ($urandom % 2) begin
        mask_m = 16'($urandom);
        wr(12'h002, mask_m);
      end
      settle();
      check_all("R2 R3 R4 random", lv);
      oa = 12'($urandom);
      if (oa != 12'h000 && oa != 12'h002) begin
        if ($urandom % 2) wr(oa, 16'($urandom));
        rd(oa, d); chk("R8 random read", d, 16'h0);
        check_all("R8 random", lv);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule